// File: doc/BRIEF.md
# Reduction Tree Node Request Collector

This block sits at one node of a reduction tree. Child ports deliver reduction requests for an aggregation operation. Each request names the child it comes from, an operation ID, the reduction to perform, whether elements are signed, how many vector lanes are valid, and the operand vector itself. The node keeps every child's vector in an operand memory, indexed by operation slot and child. It tracks arrivals in a per-slot bitmask. Once the mask matches the configured set of member children, the operation becomes ready.

A single fold engine takes ready operations one at a time, lowest slot first. It reads the stored vectors back in ascending child index and combines them lane by lane through a reduction ALU. Because the combine order is fixed, arrival order has no effect on the result. The finished vector leaves on the parent port, or on the distribution port when the node is configured as the tree root. The slot is freed on the same clock edge that the result is emitted.

Several operations may be open at once. A long reduction is carried as several independent operation IDs. A configured cap bounds how many operation IDs may be open at one time. Every request gets a one-cycle response code that says whether it was taken or why it was refused.

Top module: `agg_collector`

## Requirements
- R1: After reset, resp_valid, up_valid and dn_valid are low, and no operation slot is open, so the first request of any ID is accepted.
- R2: No result is emitted for an operation until every child whose bit is set in cfg_child_mask has had a request accepted for it.
- R3: The result is the lane-wise fold of the member children's vectors in ascending child index. It is identical for any arrival order.
- R4: The op field selects the reduction: 0 sum (modulo 2^ELEM_W), 1 min, 2 max, 3 AND, 4 OR, 5 XOR. For min and max, compares are two's-complement when req_signed=1 and unsigned otherwise. Op codes 6 and 7 are refused with code 5.
- R5: Lanes at index req_count and above read zero in out_data. Lane l occupies bits [l*ELEM_W +: ELEM_W].
- R6: Each result raises exactly one of up_valid or dn_valid for one cycle: dn_valid when cfg_is_root=1, up_valid otherwise. out_id carries the operation ID and out_count carries the lane count.
- R7: A request for an ID that is not open is refused with code 3 while cfg_max_out IDs are open. It leaves no trace in later results.
- R8: A second request from a child already recorded for an open ID is refused with code 1. Its data is not used.
- R9: A request whose op, signedness or count differs from the first accepted request of the same open ID is refused with code 2. It is not recorded.
- R10: A request from a child whose cfg_child_mask bit is clear is refused with code 4.
- R11: The slot of an emitted operation is free from the cycle after the result, and the same ID can start a new operation at once.
- R12: Every request cycle is answered one clock later by resp_valid with resp_code; code 0 means accepted. resp_valid is low in the cycle after a cycle with no request.
- R13: Operations on different IDs may interleave their requests and each completes with its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_child_mask | input | NUM_CHILD | Children taking part in the group |
| cfg_max_out | input | ID_W+1 | Maximum number of open operation IDs |
| cfg_is_root | input | 1 | Node is the tree root |
| req_valid | input | 1 | Request present this cycle |
| req_child | input | CH_W | Child port index of the request |
| req_id | input | ID_W | Operation ID |
| req_op | input | 3 | Reduction operation code |
| req_signed | input | 1 | Elements are two's-complement |
| req_count | input | CNT_W | Number of valid lanes |
| req_data | input | LANES*ELEM_W | Operand vector |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_code | output | 3 | 0 ok, 1 duplicate, 2 header mismatch, 3 limit reached, 4 not a member, 5 bad op |
| up_valid | output | 1 | Result toward the parent |
| dn_valid | output | 1 | Result toward distribution (root) |
| out_id | output | ID_W | Operation ID of the result |
| out_count | output | CNT_W | Lane count of the result |
| out_data | output | LANES*ELEM_W | Result vector |

## Verification
The bench delivers the final child of an operation only after checking that nothing was emitted from a partial mask. A collector that fires early, or that counts a duplicate toward completion, produces a result that is missing a child. Random trials shuffle the arrival order and mix signed and unsigned min and max on full-range data. A design that folds in arrival order, or that compares with the wrong signedness, then gives a value the bench's own fold does not match. Directed cases feed a duplicate with different data, a conflicting header, a non-member child and an ID past the open-operation cap. A design that wrote any of these into the operand store shows a corrupted result later, and a design that never freed slots refuses the reused ID. Several operations are interleaved so that more than one is ready while the engine is busy.

// File: rtl/agg_pkg.sv
package agg_pkg;
  localparam logic [2:0] OP_SUM = 3'd0;
  localparam logic [2:0] OP_MIN = 3'd1;
  localparam logic [2:0] OP_MAX = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;
  localparam logic [2:0] OP_XOR = 3'd5;

  localparam logic [2:0] RSP_OK    = 3'd0;
  localparam logic [2:0] RSP_DUP   = 3'd1;
  localparam logic [2:0] RSP_HDR   = 3'd2;
  localparam logic [2:0] RSP_FULL  = 3'd3;
  localparam logic [2:0] RSP_NOMEM = 3'd4;
  localparam logic [2:0] RSP_BADOP = 3'd5;

  typedef enum logic [1:0] {ENG_IDLE, ENG_FOLD, ENG_DRAIN} eng_state_e;
endpackage

// File: rtl/agg_lane_alu.sv
module agg_lane_alu #(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import agg_pkg::*;
  logic lt;

  always_comb begin
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    case (op)
      OP_SUM:  y = a + b;
      OP_MIN:  y = lt ? a : b;
      OP_MAX:  y = lt ? b : a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/agg_operand_ram.sv
module agg_operand_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/agg_slot_table.sv
module agg_slot_table #(
  parameter int NUM_CHILD = 4,
  parameter int NUM_SLOT  = 4,
  parameter int CNT_W     = 3,
  localparam int CH_W = $clog2(NUM_CHILD),
  localparam int ID_W = $clog2(NUM_SLOT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHILD-1:0] cfg_child_mask,
  input  logic [ID_W:0]        cfg_max_out,
  input  logic                 req_valid,
  input  logic [CH_W-1:0]      req_child,
  input  logic [ID_W-1:0]      req_id,
  input  logic [2:0]           req_op,
  input  logic                 req_signed,
  input  logic [CNT_W-1:0]     req_count,
  output logic [2:0]           code,
  output logic                 accept,
  input  logic                 free_valid,
  input  logic [ID_W-1:0]      free_id,
  input  logic [ID_W-1:0]      sel_id,
  output logic [2:0]           sel_op,
  output logic                 sel_signed,
  output logic [CNT_W-1:0]     sel_count,
  output logic [NUM_SLOT-1:0]  ready,
  output logic [NUM_SLOT-1:0]  active
);
  import agg_pkg::*;

  logic [NUM_CHILD-1:0] mask_q [NUM_SLOT];
  logic [2:0]           hop_q  [NUM_SLOT];
  logic                 hsgn_q [NUM_SLOT];
  logic [CNT_W-1:0]     hcnt_q [NUM_SLOT];
  logic [ID_W:0]        n_open;
  logic                 hit;

  always_comb begin
    n_open = '0;
    for (int s = 0; s < NUM_SLOT; s++) n_open = n_open + (ID_W+1)'(active[s]);
  end

  generate
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_rdy
      assign ready[s] = active[s] && (mask_q[s] == cfg_child_mask);
    end
  endgenerate

  assign hit = active[req_id];

  always_comb begin
    if (req_op > OP_XOR)                          code = RSP_BADOP;
    else if (!cfg_child_mask[req_child])          code = RSP_NOMEM;
    else if (hit && mask_q[req_id][req_child])    code = RSP_DUP;
    else if (hit && (hop_q[req_id] != req_op || hsgn_q[req_id] != req_signed ||
                     hcnt_q[req_id] != req_count)) code = RSP_HDR;
    else if (!hit && n_open >= cfg_max_out)       code = RSP_FULL;
    else                                          code = RSP_OK;
    accept = req_valid && (code == RSP_OK);
  end

  assign sel_op     = hop_q[sel_id];
  assign sel_signed = hsgn_q[sel_id];
  assign sel_count  = hcnt_q[sel_id];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      for (int s = 0; s < NUM_SLOT; s++) begin
        mask_q[s] <= '0;
        hop_q[s]  <= '0;
        hsgn_q[s] <= 1'b0;
        hcnt_q[s] <= '0;
      end
    end else begin
      if (free_valid) begin
        active[free_id] <= 1'b0;
        mask_q[free_id] <= '0;
      end
      if (accept) begin
        active[req_id] <= 1'b1;
        mask_q[req_id][req_child] <= 1'b1;
        if (!hit) begin
          hop_q[req_id]  <= req_op;
          hsgn_q[req_id] <= req_signed;
          hcnt_q[req_id] <= req_count;
        end
      end
    end
  end
endmodule

// File: rtl/agg_collector.sv
module agg_collector #(
  parameter int NUM_CHILD = 4,
  parameter int NUM_SLOT  = 4,
  parameter int LANES     = 4,
  parameter int ELEM_W    = 32,
  localparam int CH_W  = $clog2(NUM_CHILD),
  localparam int ID_W  = $clog2(NUM_SLOT),
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int VEC_W = LANES * ELEM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHILD-1:0] cfg_child_mask,
  input  logic [ID_W:0]        cfg_max_out,
  input  logic                 cfg_is_root,
  input  logic                 req_valid,
  input  logic [CH_W-1:0]      req_child,
  input  logic [ID_W-1:0]      req_id,
  input  logic [2:0]           req_op,
  input  logic                 req_signed,
  input  logic [CNT_W-1:0]     req_count,
  input  logic [VEC_W-1:0]     req_data,
  output logic                 resp_valid,
  output logic [2:0]           resp_code,
  output logic                 up_valid,
  output logic                 dn_valid,
  output logic [ID_W-1:0]      out_id,
  output logic [CNT_W-1:0]     out_count,
  output logic [VEC_W-1:0]     out_data
);
  import agg_pkg::*;

  localparam int DEPTH = NUM_SLOT * NUM_CHILD;
  localparam int AW    = $clog2(DEPTH);

  eng_state_e          state;
  logic [ID_W-1:0]     eng_slot;
  logic [CH_W-1:0]     ci;
  logic                rd_vld, rd_use, acc_loaded;
  logic [VEC_W-1:0]    acc, acc_next, alu_y, rdata, masked;
  logic [2:0]          code, sel_op;
  logic                accept, sel_signed, free_valid, pick_any;
  logic [CNT_W-1:0]    sel_count;
  logic [NUM_SLOT-1:0] ready, slot_active;
  logic [ID_W-1:0]     pick_id;
  logic [AW-1:0]       waddr, raddr;

  agg_slot_table #(.NUM_CHILD(NUM_CHILD), .NUM_SLOT(NUM_SLOT), .CNT_W(CNT_W)) u_tab (
    .clk(clk), .rst(rst), .cfg_child_mask(cfg_child_mask), .cfg_max_out(cfg_max_out),
    .req_valid(req_valid), .req_child(req_child), .req_id(req_id), .req_op(req_op),
    .req_signed(req_signed), .req_count(req_count), .code(code), .accept(accept),
    .free_valid(free_valid), .free_id(eng_slot), .sel_id(eng_slot), .sel_op(sel_op),
    .sel_signed(sel_signed), .sel_count(sel_count), .ready(ready), .active(slot_active)
  );

  assign waddr = AW'(req_id) * AW'(NUM_CHILD) + AW'(req_child);
  assign raddr = AW'(eng_slot) * AW'(NUM_CHILD) + AW'(ci);

  agg_operand_ram #(.DEPTH(DEPTH), .WIDTH(VEC_W)) u_ram (
    .clk(clk), .we(accept), .waddr(waddr), .wdata(req_data),
    .re(state == ENG_FOLD), .raddr(raddr), .rdata(rdata)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      agg_lane_alu #(.W(ELEM_W)) u_alu (
        .op(sel_op), .sgn(sel_signed),
        .a(acc[l*ELEM_W +: ELEM_W]), .b(rdata[l*ELEM_W +: ELEM_W]),
        .y(alu_y[l*ELEM_W +: ELEM_W])
      );
      assign masked[l*ELEM_W +: ELEM_W] =
        (CNT_W'(l) < sel_count) ? acc_next[l*ELEM_W +: ELEM_W] : '0;
    end
  endgenerate

  assign acc_next   = (rd_vld && rd_use) ? (acc_loaded ? alu_y : rdata) : acc;
  assign free_valid = (state == ENG_DRAIN);

  always_comb begin
    pick_any = 1'b0;
    pick_id  = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--) begin
      if (ready[s]) begin
        pick_any = 1'b1;
        pick_id  = ID_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ENG_IDLE;
      eng_slot   <= '0;
      ci         <= '0;
      rd_vld     <= 1'b0;
      rd_use     <= 1'b0;
      acc        <= '0;
      acc_loaded <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= '0;
      up_valid   <= 1'b0;
      dn_valid   <= 1'b0;
      out_id     <= '0;
      out_count  <= '0;
      out_data   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_code  <= code;
      rd_vld     <= (state == ENG_FOLD);
      rd_use     <= cfg_child_mask[ci];
      acc        <= acc_next;
      if (rd_vld && rd_use) acc_loaded <= 1'b1;
      up_valid   <= 1'b0;
      dn_valid   <= 1'b0;
      case (state)
        ENG_IDLE: if (pick_any) begin
          state      <= ENG_FOLD;
          eng_slot   <= pick_id;
          ci         <= '0;
          acc_loaded <= 1'b0;
        end
        ENG_FOLD: begin
          ci <= ci + 1'b1;
          if (ci == CH_W'(NUM_CHILD - 1)) state <= ENG_DRAIN;
        end
        ENG_DRAIN: begin
          state     <= ENG_IDLE;
          up_valid  <= !cfg_is_root;
          dn_valid  <= cfg_is_root;
          out_id    <= eng_slot;
          out_count <= sel_count;
          out_data  <= masked;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/agg_collector_chk.sv
module agg_collector_chk #(
  parameter int NS   = 4,
  parameter int ID_W = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          resp_valid,
  input logic          up_valid,
  input logic          dn_valid,
  input logic          cfg_is_root,
  input logic [ID_W:0] cfg_max_out,
  input logic [NS-1:0] slot_active
);
  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    !(up_valid && dn_valid));
  a_r6_root_dir: assert property (@(posedge clk) disable iff (rst)
    (up_valid || dn_valid) |-> (dn_valid == cfg_is_root));
  a_r12_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  a_r7_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_active) <= int'(cfg_max_out));
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (up_valid || dn_valid) |=> !(up_valid || dn_valid));
endmodule

bind agg_collector agg_collector_chk #(.NS(NUM_SLOT), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .resp_valid(resp_valid),
  .up_valid(up_valid), .dn_valid(dn_valid), .cfg_is_root(cfg_is_root),
  .cfg_max_out(cfg_max_out), .slot_active(slot_active)
);

// File: tb/sim_agg_collector.sv
module sim_agg_collector;
  localparam int CLK_P = 10;
  localparam int NC = 4, NS = 4, L = 4, W = 32;
  localparam int VW = L * W;

  logic clk = 1'b0, rst = 1'b1;
  logic [NC-1:0] cfg_child_mask = '1;
  logic [2:0] cfg_max_out = 3'd4;
  logic cfg_is_root = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_child = '0, req_id = '0;
  logic [2:0] req_op = '0;
  logic req_signed = 1'b0;
  logic [2:0] req_count = '0;
  logic [VW-1:0] req_data = '0;
  logic resp_valid, up_valid, dn_valid;
  logic [2:0] resp_code, out_count;
  logic [1:0] out_id;
  logic [VW-1:0] out_data;

  int checks = 0, fails = 0;
  int got [NS];
  logic [VW-1:0] gdata [NS];
  logic gup [NS], gdn [NS];
  logic [VW-1:0] vec [NS][NC];

  always #(CLK_P/2) clk = ~clk;

  agg_collector u0 (
    .clk(clk), .rst(rst), .cfg_child_mask(cfg_child_mask), .cfg_max_out(cfg_max_out),
    .cfg_is_root(cfg_is_root), .req_valid(req_valid), .req_child(req_child),
    .req_id(req_id), .req_op(req_op), .req_signed(req_signed), .req_count(req_count),
    .req_data(req_data), .resp_valid(resp_valid), .resp_code(resp_code),
    .up_valid(up_valid), .dn_valid(dn_valid), .out_id(out_id), .out_count(out_count),
    .out_data(out_data)
  );

  initial for (int i = 0; i < NS; i++) got[i] = 0;

  always @(negedge clk) begin
    if (up_valid || dn_valid) begin
      got[out_id]   = got[out_id] + 1;
      gdata[out_id] = out_data;
      gup[out_id]   = up_valid;
      gdn[out_id]   = dn_valid;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane_op(input int op, input logic sg,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    logic lt;
    lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    case (op)
      0: return a + b;
      1: return lt ? a : b;
      2: return lt ? b : a;
      3: return a & b;
      4: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [VW-1:0] fold(input int id, input int op, input logic sg,
                                         input int cnt, input logic [NC-1:0] m);
    logic [VW-1:0] r;
    logic first;
    r = '0;
    first = 1'b1;
    for (int c = 0; c < NC; c++) begin
      if (m[c]) begin
        if (first) r = vec[id][c];
        else for (int l = 0; l < L; l++)
          r[l*W +: W] = lane_op(op, sg, r[l*W +: W], vec[id][c][l*W +: W]);
        first = 1'b0;
      end
    end
    for (int l = 0; l < L; l++) if (l >= cnt) r[l*W +: W] = '0;
    return r;
  endfunction

  task automatic send(input int ch, input int id, input int op, input logic sg,
                      input int cnt, input logic [VW-1:0] d, output logic [2:0] code);
    @(negedge clk);
    req_valid = 1'b1; req_child = ch[1:0]; req_id = id[1:0]; req_op = op[2:0];
    req_signed = sg; req_count = cnt[2:0]; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    code = resp_valid ? resp_code : 3'd7;
  endtask

  task automatic expect_code(input int ch, input int id, input int op, input logic sg,
                             input int cnt, input logic [VW-1:0] d,
                             input logic [2:0] exp, input string req);
    logic [2:0] c;
    send(ch, id, op, sg, cnt, d, c);
    chk(c == exp, req, VW'(c), VW'(exp));
  endtask

  task automatic wait_res(input int id, input int prev);
    for (int i = 0; i < 200; i++) begin
      if (got[id] != prev) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int l = 0; l < L; l++) v[l*W +: W] = $urandom;
    return v;
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [VW-1:0] e;
    int p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!resp_valid && !up_valid && !dn_valid, "R1 outputs idle", 0, 0);

    // R2 R3 R6 R12: sum, reverse arrival
    for (int c = 0; c < NC; c++) vec[0][c] = rvec();
    for (int c = NC - 1; c > 0; c--) expect_code(c, 0, 0, 0, 4, vec[0][c], 3'd0, "R12 accept");
    p = got[0];
    repeat (20) @(negedge clk);
    chk(got[0] == p, "R2 no early result", VW'(got[0]), VW'(p));
    expect_code(0, 0, 0, 0, 4, vec[0][0], 3'd0, "R1 first id open");
    wait_res(0, p);
    e = fold(0, 0, 0, 4, 4'hF);
    chk(gdata[0] == e, "R3 sum result", gdata[0], e);
    chk(gup[0] && !gdn[0], "R6 parent port", {gup[0], gdn[0]}, 2'b10);

    // R8 R9: duplicate and header mismatch, signed min
    for (int c = 0; c < NC; c++) vec[1][c] = rvec();
    vec[1][0][W-1] = 1'b1;
    expect_code(0, 1, 1, 1, 4, vec[1][0], 3'd0, "R12 accept");
    expect_code(0, 1, 1, 1, 4, ~vec[1][0], 3'd1, "R8 duplicate");
    expect_code(1, 1, 2, 1, 4, vec[1][1], 3'd2, "R9 op mismatch");
    expect_code(1, 1, 1, 1, 3, vec[1][1], 3'd2, "R9 count mismatch");
    expect_code(1, 1, 1, 0, 4, vec[1][1], 3'd2, "R9 sign mismatch");
    expect_code(3, 1, 6, 1, 4, vec[1][3], 3'd5, "R4 bad op");
    p = got[1];
    for (int c = 1; c < NC; c++) expect_code(c, 1, 1, 1, 4, vec[1][c], 3'd0, "R12 accept");
    wait_res(1, p);
    e = fold(1, 1, 1, 4, 4'hF);
    chk(gdata[1] == e, "R8 R9 R4 signed min after rejects", gdata[1], e);

    // R10 R5 R6: partial membership, short count, root
    @(negedge clk);
    cfg_child_mask = 4'b1011; cfg_is_root = 1'b1;
    for (int c = 0; c < NC; c++) vec[2][c] = rvec();
    expect_code(2, 2, 2, 0, 2, vec[2][2], 3'd4, "R10 non-member");
    p = got[2];
    expect_code(3, 2, 2, 0, 2, vec[2][3], 3'd0, "R12 accept");
    expect_code(0, 2, 2, 0, 2, vec[2][0], 3'd0, "R12 accept");
    expect_code(1, 2, 2, 0, 2, vec[2][1], 3'd0, "R12 accept");
    wait_res(2, p);
    e = fold(2, 2, 0, 2, 4'b1011);
    chk(gdata[2] == e, "R5 R10 unsigned max two lanes", gdata[2], e);
    chk(gdn[2] && !gup[2], "R6 root port", {gup[2], gdn[2]}, 2'b01);

    // R7 R11: outstanding cap and slot reuse
    @(negedge clk);
    cfg_child_mask = 4'hF; cfg_is_root = 1'b0; cfg_max_out = 3'd2;
    for (int i = 0; i < 3; i++) for (int c = 0; c < NC; c++) vec[i][c] = rvec();
    expect_code(0, 0, 4, 0, 4, vec[0][0], 3'd0, "R12 accept");
    expect_code(0, 1, 3, 0, 4, vec[1][0], 3'd0, "R12 accept");
    expect_code(0, 2, 5, 0, 4, ~vec[2][0], 3'd3, "R7 cap reached");
    p = got[0];
    for (int c = 1; c < NC; c++) expect_code(c, 0, 4, 0, 4, vec[0][c], 3'd0, "R12 accept");
    wait_res(0, p);
    e = fold(0, 4, 0, 4, 4'hF);
    chk(gdata[0] == e, "R3 or result", gdata[0], e);
    expect_code(0, 2, 5, 0, 4, vec[2][0], 3'd0, "R7 slot available after free");
    expect_code(0, 0, 0, 0, 4, vec[0][0], 3'd3, "R7 cap again");
    p = got[2];
    for (int c = 1; c < NC; c++) expect_code(c, 2, 5, 0, 4, vec[2][c], 3'd0, "R12 accept");
    wait_res(2, p);
    e = fold(2, 5, 0, 4, 4'hF);
    chk(gdata[2] == e, "R7 refused data unused", gdata[2], e);
    for (int c = 0; c < NC; c++) vec[0][c] = rvec();
    expect_code(0, 0, 3, 0, 4, vec[0][0], 3'd0, "R11 id reuse");
    p = got[1];
    for (int c = 1; c < NC; c++) expect_code(c, 1, 3, 0, 4, vec[1][c], 3'd0, "R12 accept");
    wait_res(1, p);
    e = fold(1, 3, 0, 4, 4'hF);
    chk(gdata[1] == e, "R4 and result", gdata[1], e);
    p = got[0];
    for (int c = 1; c < NC; c++) expect_code(c, 0, 3, 0, 4, vec[0][c], 3'd0, "R12 accept");
    wait_res(0, p);
    e = fold(0, 3, 0, 4, 4'hF);
    chk(gdata[0] == e, "R11 reused id result", gdata[0], e);

    // R13 interleaved operations
    @(negedge clk);
    cfg_max_out = 3'd4;
    begin
      int pr [NS];
      for (int i = 0; i < NS; i++) begin
        pr[i] = got[i];
        for (int c = 0; c < NC; c++) vec[i][c] = rvec();
      end
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NS; i++)
          expect_code(c, i, i, 1'(i), 4, vec[i][c], 3'd0, "R13 interleaved accept");
      for (int i = 0; i < NS; i++) begin
        wait_res(i, pr[i]);
        e = fold(i, i, 1'(i), 4, 4'hF);
        chk(gdata[i] == e, "R13 interleaved result", gdata[i], e);
      end
    end

    // R3 R4 R5 random trials with shuffled arrival
    for (int t = 0; t < 40; t++) begin
      int op, cnt, id, ord [NC];
      logic sg;
      logic [NC-1:0] m;
      op = $urandom_range(0, 5); cnt = $urandom_range(0, 4);
      id = $urandom_range(0, NS - 1); sg = 1'($urandom_range(0, 1));
      m = 4'($urandom_range(1, 15));
      @(negedge clk);
      cfg_child_mask = m; cfg_is_root = 1'($urandom_range(0, 1));
      for (int c = 0; c < NC; c++) begin
        vec[id][c] = rvec();
        ord[c] = c;
      end
      for (int c = NC - 1; c > 0; c--) begin
        int j, tmp;
        j = $urandom_range(0, c);
        tmp = ord[c]; ord[c] = ord[j]; ord[j] = tmp;
      end
      p = got[id];
      for (int k = 0; k < NC; k++)
        if (m[ord[k]]) expect_code(ord[k], id, op, sg, cnt, vec[id][ord[k]], 3'd0, "R12 accept");
      wait_res(id, p);
      e = fold(id, op, sg, cnt, m);
      chk(gdata[id] == e, "R3 R4 R5 random fold", gdata[id], e);
      chk(gdn[id] == cfg_is_root && gup[id] == !cfg_is_root, "R6 random direction",
          {gup[id], gdn[id]}, {!cfg_is_root, cfg_is_root});
    end

    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule